// File: doc/BRIEF.md
# Speculative Synchronization Controller

This controller sits beside one processor's cache hierarchy and takes charge of a single synchronization variable, so that the processor can run ahead past a busy lock or an unset flag instead of waiting. When a lock or flag request arrives while the controller is free, it asks the processor to checkpoint its registers. It then reads the variable through a memory port. While the variable does not permit progress, it waits for a coherence update on that address before reading again. When the variable does permit progress, it tells the cache tracker to commit every speculatively marked line at once.

Two state bits steer the lock case. One bit marks a pending acquire. The other bit marks a release that has not yet happened. A release store issued by the processor while an acquire is pending is absorbed and clears the release bit. A thread that finished its whole critical section while still speculative therefore becomes safe as soon as the lock reads free, and it never performs a test-and-set. A flag wait runs on the same machine with the release bit clear from the start. It completes when the flag value matches the pass value given with the request.

A conflict squash sends a gang squash and a checkpoint restore. The wait for the variable continues. In lock mode the squash also re-arms the release bit. A preemption or exception also squashes the thread, and in addition it frees the controller. The idle output lets software wait for the controller before it enters code that must not speculate.

Top module: `spec_sync_ctrl`

## Requirements
- R1: After reset, `idle` is 1 and `mem_req_valid`, `gang_commit`, `gang_squash`, `ckpt_restore`, `req_accept` and `req_reject` are 0.
- R2: A request while idle gives `req_accept`=1 and `ckpt_take`=1 in that cycle. In the next cycle `idle` is 0 and a plain load (`mem_req_valid`=1, `mem_req_tas`=0) to the request address is issued.
- R3: In lock mode, a nonzero read counts as busy. No further memory request is made until `upd_valid` arrives with `upd_addr` equal to the held address, and an update to any other address is ignored. The load is reissued in the cycle after the matching update.
- R4: In lock mode with the release bit set, a zero read issues a test-and-set (`mem_req_tas`=1) in the next cycle. A test-and-set response of 0 pulses `gang_commit` in that response cycle, and `idle` is 1 in the next cycle. A nonzero response returns to waiting for an update, with no commit.
- R5: A release store (`rel_valid`) while not idle is not forwarded (`rel_fwd_valid`=0) and clears the release bit. A later zero read then commits in the response cycle with no test-and-set.
- R6: A release store while idle is forwarded in the same cycle, with its address and data unchanged.
- R7: A flag request (`req_is_flag`=1) commits in the cycle of a read whose data equals `req_pass`. Any other value, zero included, waits for a matching update. A flag wait never issues a test-and-set.
- R8: A request while not idle gives no checkpoint. If its address differs from the held one it is rejected (`req_reject`=1). If the address is the same it is merged (`req_accept`=1), and the wait in progress continues.
- R9: A `squash_in` while not idle pulses `gang_squash` and `ckpt_restore` in that cycle, and the controller stays busy. In lock mode it sets the release bit again, so a later free read issues a test-and-set.
- R10: A squash in flag mode leaves the release bit clear, so a matching read still commits with no test-and-set.
- R11: A `preempt_in` while not idle pulses `gang_squash` and `ckpt_restore`, and `idle` is 1 in the next cycle. A new request is then accepted with a checkpoint.
- R12: `squash_in` or `preempt_in` while idle causes no output pulse, and a memory response while idle causes no commit.
- R13: If a commit and a squash fall in the same cycle, the commit wins: `gang_commit`=1 and `gang_squash`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lock or flag request from the processor |
| req_is_flag | input | 1 | 1 = flag wait, 0 = lock acquire |
| req_addr | input | AW | Address of the synchronization variable |
| req_pass | input | DW | Pass value for a flag wait |
| req_accept | output | 1 | Request taken (new or merged) |
| req_reject | output | 1 | Request refused; the processor handles it in software |
| ckpt_take | output | 1 | Processor must checkpoint its registers |
| rel_valid | input | 1 | Release store from the processor |
| rel_addr | input | AW | Release store address |
| rel_data | input | DW | Release store data |
| rel_fwd_valid | output | 1 | Release store passed on to memory |
| rel_fwd_addr | output | AW | Forwarded release address |
| rel_fwd_data | output | DW | Forwarded release data |
| squash_in | input | 1 | Conflict on a speculative line |
| preempt_in | input | 1 | Preemption or exception |
| mem_req_valid | output | 1 | Memory operation issued |
| mem_req_tas | output | 1 | 1 = test-and-set, 0 = load |
| mem_req_addr | output | AW | Address of the memory operation |
| mem_rsp_valid | input | 1 | Memory response |
| mem_rsp_data | input | DW | Loaded value, or old value for a test-and-set (0 = won) |
| upd_valid | input | 1 | Coherence update notification |
| upd_addr | input | AW | Address that was updated |
| gang_commit | output | 1 | Commit all speculative lines |
| gang_squash | output | 1 | Discard all speculative lines |
| ckpt_restore | output | 1 | Processor restores its checkpoint |
| idle | output | 1 | Controller free |

## Verification
The lock path is swept over every combination of three inputs: a release store absorbed or not, a busy or a free first read, and a won or a lost test-and-set. Comparing these runs shows whether the release bit alone decides that a free read skips the test-and-set. Flag waits are tried with first reads that match the pass value, that read zero, and that read some other value. This separates flag completion from the zero-means-free rule of the lock path. Separate sequences combine squash, preemption and merged or rejected second requests with those paths. They show that a squash re-arms the release bit only for locks and that a commit in the same cycle outranks a squash.

// File: rtl/spec_sync_pkg.sv
package spec_sync_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LD_REQ,
    ST_LD_WAIT,
    ST_WAIT_UPD,
    ST_TAS_REQ,
    ST_TAS_WAIT
  } ctl_state_e;

  typedef enum logic {
    MODE_LOCK = 1'b0,
    MODE_FLAG = 1'b1
  } sync_mode_e;
endpackage

// File: rtl/ssc_track.sv
module ssc_track
  import spec_sync_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_start,
  input  sync_mode_e    start_kind,
  input  logic [AW-1:0] start_addr,
  input  logic [DW-1:0] start_pass,
  input  logic          ev_commit,
  input  logic          ev_preempt,
  input  logic          ev_squash,
  input  logic          ev_intercept,
  output logic          acq_q,
  output logic          rel_q,
  output sync_mode_e    mode_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] pass_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acq_q  <= 1'b0;
      rel_q  <= 1'b0;
      mode_q <= MODE_LOCK;
      addr_q <= '0;
      pass_q <= '0;
    end else if (ev_start) begin
      acq_q  <= 1'b1;
      rel_q  <= (start_kind == MODE_LOCK);
      mode_q <= start_kind;
      addr_q <= start_addr;
      pass_q <= start_pass;
    end else if (ev_commit || ev_preempt) begin
      acq_q <= 1'b0;
      rel_q <= 1'b0;
    end else if (ev_squash) begin
      // the rolled-back thread has not released yet: re-arm only for locks
      if (mode_q == MODE_LOCK) rel_q <= 1'b1;
    end else if (ev_intercept) begin
      rel_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ssc_seq.sv
module ssc_seq
  import spec_sync_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic          acq,
  input  logic          rel_bit,
  input  sync_mode_e    mode,
  input  logic [AW-1:0] cur_addr,
  input  logic [DW-1:0] cur_pass,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  input  logic          upd_valid,
  input  logic [AW-1:0] upd_addr,
  input  logic          squash_in,
  input  logic          preempt_in,
  output ctl_state_e    state_o,
  output logic          mem_req_valid,
  output logic          mem_req_tas,
  output logic          ev_start,
  output logic          ev_merge,
  output logic          ev_reject,
  output logic          ev_commit,
  output logic          ev_squash,
  output logic          ev_preempt
);
  function automatic logic var_free(input logic [DW-1:0] v);
    return v == '0;
  endfunction

  function automatic logic flag_open(input logic [DW-1:0] v, input logic [DW-1:0] p);
    return v == p;
  endfunction

  ctl_state_e state_q, state_d;

  logic rsp_ld, rsp_tas, ld_done, ld_tas, ld_busy, tas_win, tas_lose, upd_hit;

  assign rsp_ld   = (state_q == ST_LD_WAIT) && mem_rsp_valid;
  assign rsp_tas  = (state_q == ST_TAS_WAIT) && mem_rsp_valid;
  assign ld_done  = rsp_ld && ((mode == MODE_FLAG) ? flag_open(mem_rsp_data, cur_pass)
                                                   : (var_free(mem_rsp_data) && !rel_bit));
  assign ld_tas   = rsp_ld && (mode == MODE_LOCK) && var_free(mem_rsp_data) && rel_bit;
  assign ld_busy  = rsp_ld && !ld_done && !ld_tas;
  assign tas_win  = rsp_tas && var_free(mem_rsp_data);
  assign tas_lose = rsp_tas && !var_free(mem_rsp_data);
  assign upd_hit  = upd_valid && (upd_addr == cur_addr);

  assign ev_commit  = ld_done || tas_win;
  assign ev_preempt = preempt_in && acq && !ev_commit;
  assign ev_squash  = (squash_in || preempt_in) && acq && !ev_commit;
  assign ev_start   = req_valid && !acq;
  assign ev_merge   = req_valid && acq && (req_addr == cur_addr);
  assign ev_reject  = req_valid && acq && (req_addr != cur_addr);

  assign mem_req_valid = (state_q == ST_LD_REQ) || (state_q == ST_TAS_REQ);
  assign mem_req_tas   = (state_q == ST_TAS_REQ);
  assign state_o       = state_q;

  always_comb begin
    state_d = state_q;
    if (state_q == ST_IDLE) begin
      if (ev_start) state_d = ST_LD_REQ;
    end else if (ev_commit || ev_preempt) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_LD_REQ:   state_d = ST_LD_WAIT;
        ST_LD_WAIT:  if (ld_tas) state_d = ST_TAS_REQ;
                     else if (ld_busy) state_d = ST_WAIT_UPD;
        ST_WAIT_UPD: if (upd_hit) state_d = ST_LD_REQ;
        ST_TAS_REQ:  state_d = ST_TAS_WAIT;
        ST_TAS_WAIT: if (tas_lose) state_d = ST_WAIT_UPD;
        default:     state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/spec_sync_ctrl.sv
module spec_sync_ctrl
  import spec_sync_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_is_flag,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_pass,
  output logic          req_accept,
  output logic          req_reject,
  output logic          ckpt_take,
  input  logic          rel_valid,
  input  logic [AW-1:0] rel_addr,
  input  logic [DW-1:0] rel_data,
  output logic          rel_fwd_valid,
  output logic [AW-1:0] rel_fwd_addr,
  output logic [DW-1:0] rel_fwd_data,
  input  logic          squash_in,
  input  logic          preempt_in,
  output logic          mem_req_valid,
  output logic          mem_req_tas,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  input  logic          upd_valid,
  input  logic [AW-1:0] upd_addr,
  output logic          gang_commit,
  output logic          gang_squash,
  output logic          ckpt_restore,
  output logic          idle
);
  logic          acq_q, rel_q;
  sync_mode_e    mode_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] pass_q;
  ctl_state_e    fsm_state;
  logic ev_start, ev_merge, ev_reject, ev_commit, ev_squash, ev_preempt, ev_intercept;

  assign ev_intercept = rel_valid && acq_q;

  ssc_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_addr(req_addr),
    .acq(acq_q), .rel_bit(rel_q), .mode(mode_q),
    .cur_addr(addr_q), .cur_pass(pass_q),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .upd_valid(upd_valid), .upd_addr(upd_addr),
    .squash_in(squash_in), .preempt_in(preempt_in),
    .state_o(fsm_state),
    .mem_req_valid(mem_req_valid), .mem_req_tas(mem_req_tas),
    .ev_start(ev_start), .ev_merge(ev_merge), .ev_reject(ev_reject),
    .ev_commit(ev_commit), .ev_squash(ev_squash), .ev_preempt(ev_preempt)
  );

  ssc_track #(.AW(AW), .DW(DW)) u_track (
    .clk(clk), .rst_n(rst_n),
    .ev_start(ev_start),
    .start_kind(req_is_flag ? MODE_FLAG : MODE_LOCK),
    .start_addr(req_addr), .start_pass(req_pass),
    .ev_commit(ev_commit), .ev_preempt(ev_preempt),
    .ev_squash(ev_squash), .ev_intercept(ev_intercept),
    .acq_q(acq_q), .rel_q(rel_q), .mode_q(mode_q),
    .addr_q(addr_q), .pass_q(pass_q)
  );

  assign req_accept    = ev_start || ev_merge;
  assign req_reject    = ev_reject;
  assign ckpt_take     = ev_start;
  assign rel_fwd_valid = rel_valid && !acq_q;
  assign rel_fwd_addr  = rel_addr;
  assign rel_fwd_data  = rel_data;
  assign mem_req_addr  = addr_q;
  assign gang_commit   = ev_commit;
  assign gang_squash   = ev_squash;
  assign ckpt_restore  = ev_squash;
  assign idle          = !acq_q;
endmodule

// File: rtl/ssc_checker.sv
module ssc_checker
  import spec_sync_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       idle,
  input logic       ckpt_take,
  input logic       req_accept,
  input logic       req_reject,
  input logic       gang_commit,
  input logic       gang_squash,
  input logic       rel_fwd_valid,
  input logic       mem_req_valid,
  input logic       mem_req_tas,
  input ctl_state_e fsm_state,
  input logic       acq
);
  // R1
  mem_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !idle);
  // R2
  ckpt_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_take |-> idle);
  // R2
  load_after_ckpt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ckpt_take |=> (!idle && mem_req_valid && !mem_req_tas));
  // R2
  state_bit_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acq == (fsm_state != ST_IDLE));
  // R4
  commit_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gang_commit |=> idle);
  // R6
  fwd_only_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_fwd_valid |-> idle);
  // R8
  reject_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_reject |-> (!idle && !ckpt_take && !req_accept));
  // R12
  squash_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gang_squash |-> !idle);
  // R13
  commit_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(gang_commit && gang_squash));
  // R11
  idle_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle) |-> $past(gang_commit || gang_squash));
endmodule

bind spec_sync_ctrl ssc_checker u_ssc_chk (
  .clk(clk), .rst_n(rst_n), .idle(idle), .ckpt_take(ckpt_take),
  .req_accept(req_accept), .req_reject(req_reject),
  .gang_commit(gang_commit), .gang_squash(gang_squash),
  .rel_fwd_valid(rel_fwd_valid), .mem_req_valid(mem_req_valid),
  .mem_req_tas(mem_req_tas), .fsm_state(fsm_state), .acq(acq_q)
);

// File: tb/spec_sync_ctrl_bench.sv
module spec_sync_ctrl_bench;
  localparam int AW = 16;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid, req_is_flag, rel_valid, squash_in, preempt_in, mem_rsp_valid, upd_valid;
  logic [AW-1:0] req_addr, rel_addr, upd_addr, rel_fwd_addr, mem_req_addr;
  logic [DW-1:0] req_pass, rel_data, mem_rsp_data, rel_fwd_data;
  logic req_accept, req_reject, ckpt_take, rel_fwd_valid, mem_req_valid, mem_req_tas;
  logic gang_commit, gang_squash, ckpt_restore, idle;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  spec_sync_ctrl #(.AW(AW), .DW(DW)) u_spec_sync_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_is_flag(req_is_flag), .req_addr(req_addr), .req_pass(req_pass),
    .req_accept(req_accept), .req_reject(req_reject), .ckpt_take(ckpt_take),
    .rel_valid(rel_valid), .rel_addr(rel_addr), .rel_data(rel_data),
    .rel_fwd_valid(rel_fwd_valid), .rel_fwd_addr(rel_fwd_addr), .rel_fwd_data(rel_fwd_data),
    .squash_in(squash_in), .preempt_in(preempt_in),
    .mem_req_valid(mem_req_valid), .mem_req_tas(mem_req_tas), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .upd_valid(upd_valid), .upd_addr(upd_addr),
    .gang_commit(gang_commit), .gang_squash(gang_squash), .ckpt_restore(ckpt_restore),
    .idle(idle)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clr();
    req_valid = 0; rel_valid = 0; squash_in = 0; preempt_in = 0;
    mem_rsp_valid = 0; upd_valid = 0;
  endtask

  task automatic next();
    @(posedge clk);
    #2;
    clr();
  endtask

  task automatic lock_run(input bit pre_rel, input bit busy, input bit tfail,
                          input logic [AW-1:0] a);
    req_valid = 1; req_is_flag = 0; req_addr = a; #1;
    chk("R2 accept", req_accept, 1); chk("R2 ckpt", ckpt_take, 1);
    next();
    #1;
    chk("R2 busy", idle, 0); chk("R2 load", mem_req_valid, 1);
    chk("R2 not tas", mem_req_tas, 0); chk("R2 addr", mem_req_addr, a);
    if (pre_rel) begin
      rel_valid = 1; rel_addr = a; rel_data = 0; #1;
      chk("R5 intercept", rel_fwd_valid, 0);
    end
    next();
    if (busy) begin
      mem_rsp_valid = 1; mem_rsp_data = 1; #1;
      chk("R3 busy no commit", gang_commit, 0);
      next();
      upd_valid = 1; upd_addr = a ^ 16'h1; #1;
      chk("R3 waiting", mem_req_valid, 0);
      next();
      #1 chk("R3 foreign update ignored", mem_req_valid, 0);
      upd_valid = 1; upd_addr = a;
      next();
      #1 chk("R3 reload", mem_req_valid, 1); chk("R3 reload is load", mem_req_tas, 0);
      next();
    end
    mem_rsp_valid = 1; mem_rsp_data = 0; #1;
    if (pre_rel) begin
      chk("R5 commit without tas", gang_commit, 1);
      next();
      #1 chk("R5 idle", idle, 1);
    end else begin
      chk("R4 no commit before tas", gang_commit, 0);
      next();
      #1 chk("R4 tas issued", mem_req_valid, 1); chk("R4 tas flag", mem_req_tas, 1);
      next();
      if (tfail) begin
        mem_rsp_valid = 1; mem_rsp_data = 1; #1;
        chk("R4 lost tas no commit", gang_commit, 0);
        next();
        #1 chk("R4 waits after loss", mem_req_valid, 0); chk("R4 still busy", idle, 0);
        upd_valid = 1; upd_addr = a;
        next();
        next();
        mem_rsp_valid = 1; mem_rsp_data = 0;
        next();
        next();
      end
      mem_rsp_valid = 1; mem_rsp_data = 0; #1;
      chk("R4 tas won commit", gang_commit, 1);
      next();
      #1 chk("R4 idle after win", idle, 1);
    end
  endtask

  task automatic flag_run(input logic [DW-1:0] pass, input logic [DW-1:0] first,
                          input logic [AW-1:0] a);
    req_valid = 1; req_is_flag = 1; req_addr = a; req_pass = pass; #1;
    chk("R7 accept", req_accept, 1); chk("R7 ckpt", ckpt_take, 1);
    next();
    #1 chk("R7 load", mem_req_valid, 1); chk("R7 load not tas", mem_req_tas, 0);
    next();
    mem_rsp_valid = 1; mem_rsp_data = first; #1;
    if (first == pass) begin
      chk("R7 match commit", gang_commit, 1);
      next();
      #1 chk("R7 idle", idle, 1);
    end else begin
      chk("R7 mismatch no commit", gang_commit, 0);
      next();
      #1 chk("R7 waiting no tas", mem_req_valid, 0);
      upd_valid = 1; upd_addr = a;
      next();
      #1 chk("R7 reload", mem_req_valid, 1); chk("R7 reload not tas", mem_req_tas, 0);
      next();
      mem_rsp_valid = 1; mem_rsp_data = pass; #1;
      chk("R7 later match commit", gang_commit, 1);
      next();
      #1 chk("R7 idle", idle, 1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    clr();
    req_is_flag = 0; req_addr = '0; req_pass = '0; rel_addr = '0; rel_data = '0;
    mem_rsp_data = '0; upd_addr = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 idle", idle, 1); chk("R1 mem", mem_req_valid, 0);
    chk("R1 commit", gang_commit, 0); chk("R1 squash", gang_squash, 0);
    chk("R1 restore", ckpt_restore, 0); chk("R1 accept", req_accept, 0);
    chk("R1 reject", req_reject, 0);
    rst_n = 1;
    next();

    // R12: events while idle
    squash_in = 1; #1 chk("R12 squash idle", gang_squash, 0); chk("R12 restore idle", ckpt_restore, 0);
    next();
    preempt_in = 1; mem_rsp_valid = 1; mem_rsp_data = 0; #1;
    chk("R12 preempt idle", gang_squash, 0); chk("R12 rsp idle", gang_commit, 0);
    next();
    #1 chk("R12 still idle", idle, 1);

    // R6: forwarding while idle
    for (int i = 0; i < 3; i++) begin
      rel_valid = 1; rel_addr = 16'h0100 + 16'(i); rel_data = 32'hA0 + 32'(i); #1;
      chk("R6 fwd valid", rel_fwd_valid, 1);
      chk("R6 fwd addr", rel_fwd_addr, 16'h0100 + 16'(i));
      chk("R6 fwd data", rel_fwd_data, 32'hA0 + 32'(i));
      next();
    end

    // lock sweep: R2 R3 R4 R5
    for (int p = 0; p < 2; p++)
      for (int b = 0; b < 2; b++)
        for (int t = 0; t < 2; t++) begin
          lock_run(p[0], b[0], t[0], 16'h0040 + 16'(p * 4 + b * 2 + t));
          next();
        end

    // flag sweep: R7
    for (int q = 0; q < 2; q++)
      for (int f = 0; f < 3; f++) begin
        flag_run((q == 0) ? 32'd0 : 32'd5, (f == 0) ? 32'd0 : ((f == 1) ? 32'd3 : 32'd5),
                 16'h0200 + 16'(q * 3 + f));
        next();
      end

    // R8 + R9: reject, merge, then squash re-arms release in lock mode
    req_valid = 1; req_is_flag = 0; req_addr = 16'h0300; #1; chk("R8 first accept", req_accept, 1);
    next();
    req_valid = 1; req_addr = 16'h0301; #1;
    chk("R8 reject", req_reject, 1); chk("R8 reject no accept", req_accept, 0);
    chk("R8 reject no ckpt", ckpt_take, 0);
    next();
    req_valid = 1; req_addr = 16'h0300; rel_valid = 1; rel_addr = 16'h0300; #1;
    chk("R8 merge accept", req_accept, 1); chk("R8 merge no ckpt", ckpt_take, 0);
    chk("R8 merge no reject", req_reject, 0); chk("R5 intercept", rel_fwd_valid, 0);
    next();
    squash_in = 1; #1;
    chk("R9 squash", gang_squash, 1); chk("R9 restore", ckpt_restore, 1);
    next();
    #1 chk("R9 stays busy", idle, 0);
    mem_rsp_valid = 1; mem_rsp_data = 0; #1 chk("R9 no direct commit", gang_commit, 0);
    next();
    #1 chk("R9 tas after squash", mem_req_tas, 1); chk("R9 tas valid", mem_req_valid, 1);
    next();
    mem_rsp_valid = 1; mem_rsp_data = 0; #1 chk("R9 commit", gang_commit, 1);
    next();

    // R10: flag squash leaves release clear
    req_valid = 1; req_is_flag = 1; req_addr = 16'h0400; req_pass = 32'd7;
    next();
    next();
    squash_in = 1; #1 chk("R10 squash", gang_squash, 1);
    next();
    mem_rsp_valid = 1; mem_rsp_data = 32'd7; #1;
    chk("R10 commit no tas", gang_commit, 1); chk("R10 no tas", mem_req_tas, 0);
    next();
    #1 chk("R10 idle", idle, 1);

    // R11: preemption frees the controller
    req_valid = 1; req_is_flag = 0; req_addr = 16'h0500;
    next();
    next();
    preempt_in = 1; #1;
    chk("R11 squash", gang_squash, 1); chk("R11 restore", ckpt_restore, 1);
    next();
    #1 chk("R11 idle", idle, 1);
    req_valid = 1; req_addr = 16'h0600; #1;
    chk("R11 new accept", req_accept, 1); chk("R11 new ckpt", ckpt_take, 1);
    next();
    next();
    // R13: absorb release, then commit and squash together
    rel_valid = 1; rel_addr = 16'h0600;
    mem_rsp_valid = 1; mem_rsp_data = 32'd1;
    next();
    upd_valid = 1; upd_addr = 16'h0600;
    next();
    next();
    mem_rsp_valid = 1; mem_rsp_data = 0; squash_in = 1; #1;
    chk("R13 commit", gang_commit, 1); chk("R13 no squash", gang_squash, 0);
    next();
    #1 chk("R13 idle", idle, 1);
    next();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule